// File: doc/BRIEF.md
# Dual Programmable Timer/Counter

This peripheral holds a set of independent timer/counters, two by default, each `DATA_W` bits wide. A small word-addressed register port reaches them. Each timer has three registers: a control/status word, a load value and a read-only view of its counter.

Software picks the counting direction, whether the counter reloads at terminal count, and whether a raised event flag drives the shared interrupt line. A hold bit in the control word pins the counter to the load value until software releases it. This is how a new count is preset before a timer starts.

Typical uses:
- A periodic tick from a down-counter that reloads.
- A one-shot delay from a counter that does not reload.
- A free-running time base from an up-counter that reloads to zero.

Writes land on the rising clock edge. Reads are combinational from the address.

Top module: `dual_timer`

## Requirements
- R1: After reset every register of every timer reads 0 and `irq` is 0.
- R2: Timer k occupies byte offsets 0x10*k to 0x10*k+0xF. Within that range, the control/status word is at +0x0, the load value at +0x4 and the counter at +0x8. Offset +0xC reads 0. So does any address whose two low bits are not 00, and any address past the last timer. The counter register ignores writes.
- R3: While control bit 5 (hold) is 1, the counter takes the load register value on every clock edge, and no event is produced.
- R4: With bit 7 (run) = 1, bit 5 = 0 and bit 1 (direction) = 1, the counter decreases by one per clock.
- R5: With bit 7 = 1, bit 5 = 0 and bit 1 = 0, the counter increases by one per clock. With bit 4 (reload) = 1 and a load value of 0, it steps from all-ones to 0, giving a modulo 2^DATA_W time base.
- R6: When a running counter sits at terminal count (0 when counting down, all-ones when counting up), the next edge sets bit 8 (event flag), whatever the state of bit 6. If bit 4 = 1, the same edge copies the load value into the counter, so a down-count period is load+1 clocks.
- R7: With bit 4 = 0, the counter stays at terminal count after its event and raises no further event until bit 5 is applied again.
- R8: Writing a control word with bit 8 = 1 clears the flag, and bit 8 = 0 leaves it unchanged. Writing back a value just read therefore acknowledges the event and keeps every other setting. An event on the same edge wins over the clear.
- R9: Clearing bit 7 stops the counter, and it keeps its value.
- R10: `irq` is 1 exactly while at least one timer has both bit 8 and bit 6 set. It is a level signal.
- R11: A control write with bit 10 = 1, to any timer, sets bit 7 in all timers on the same edge. Bit 10 always reads 0.
- R12: Bits 0, 2, 3 and 9 are stored and read back. They have no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the register accessed |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request, OR over timers of flag and enable |

## Verification
The bench builds the block with two timers, a 32-bit data path, a 5-bit address and the unregistered interrupt variant. With these values the interrupt level can be compared in the same cycle as the flag it follows. Loading values a few counts below all-ones brings the up-count terminal count and the wrap to zero within a handful of cycles. Two timers are enough to show one timer's enable-all write starting its neighbour, and to show that one timer's flag alone drives the shared line.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

   // Width of the stored control/status word
   localparam int CTL_W = 11;

   // Control/status bit positions (software-visible layout)
   localparam int B_CAPMODE = 0;
   localparam int B_DOWN    = 1;
   localparam int B_GENOUT  = 2;
   localparam int B_CAPTRIG = 3;
   localparam int B_RELOAD  = 4;
   localparam int B_HOLD    = 5;
   localparam int B_IEN     = 6;
   localparam int B_RUN     = 7;
   localparam int B_FLAG    = 8;
   localparam int B_PWM     = 9;
   localparam int B_ALLGO   = 10;

   // Register slot within one timer's 16-byte window
   typedef enum logic [1:0] {
      SEL_CTL  = 2'd0,
      SEL_LOAD = 2'd1,
      SEL_CNT  = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/dtmr_channel.sv
module dtmr_channel
   import dtmr_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctl,
   input  logic              wr_load,
   input  logic              all_go,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] ctl_o,
   output logic [DATA_W-1:0] load_o,
   output logic [DATA_W-1:0] cnt_o,
   output logic              req_o,
   output logic              run_o
);

   localparam int PAD_W = DATA_W - CTL_W;

   logic [CTL_W-1:0]  ctl_q, ctl_n;
   logic [DATA_W-1:0] load_q;
   logic [DATA_W-1:0] cnt_q, cnt_n;
   logic [DATA_W-1:0] tc_w;
   logic              spent_q, spent_n;
   logic              hold_w, run_w, down_w, reload_w;
   logic              at_tc, step, evt;

   assign hold_w   = ctl_q[B_HOLD];
   assign run_w    = ctl_q[B_RUN];
   assign down_w   = ctl_q[B_DOWN];
   assign reload_w = ctl_q[B_RELOAD];

   // Terminal count depends on direction
   assign tc_w  = down_w ? '0 : '1;
   assign at_tc = (cnt_q == tc_w);
   assign step  = run_w && !hold_w && !spent_q;
   assign evt   = step && at_tc;

   // Control word next state: flag is write-one-to-clear, event wins
   always_comb begin
      ctl_n = ctl_q;
      if (wr_ctl) begin
         ctl_n         = wdata[CTL_W-1:0];
         ctl_n[B_FLAG] = ctl_q[B_FLAG] && !wdata[B_FLAG];
      end
      ctl_n[B_ALLGO] = 1'b0;
      if (all_go) begin
         ctl_n[B_RUN] = 1'b1;
      end
      if (evt) begin
         ctl_n[B_FLAG] = 1'b1;
      end
   end

   // Counter next state
   always_comb begin
      cnt_n = cnt_q;
      if (hold_w) begin
         cnt_n = load_q;
      end else if (evt) begin
         cnt_n = reload_w ? load_q : cnt_q;
      end else if (step) begin
         cnt_n = down_w ? (cnt_q - DATA_W'(1)) : (cnt_q + DATA_W'(1));
      end
   end

   // One-shot lockout: set by a non-reloading event, released by hold
   always_comb begin
      spent_n = spent_q;
      if (hold_w) begin
         spent_n = 1'b0;
      end else if (evt && !reload_w) begin
         spent_n = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q   <= '0;
         load_q  <= '0;
         cnt_q   <= '0;
         spent_q <= 1'b0;
      end else begin
         ctl_q   <= ctl_n;
         cnt_q   <= cnt_n;
         spent_q <= spent_n;
         if (wr_load) begin
            load_q <= wdata;
         end
      end
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign ctl_o = {{PAD_W{1'b0}}, ctl_q};
      end else begin : g_nopad
         assign ctl_o = ctl_q;
      end
   endgenerate

   assign load_o = load_q;
   assign cnt_o  = cnt_q;
   assign req_o  = ctl_q[B_FLAG] && ctl_q[B_IEN];
   assign run_o  = run_w;

   // R3
   hold_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold_w |=> (cnt_q == $past(load_q)));

   // R4
   down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_w && !hold_w && !spent_q && down_w && (cnt_q != '0))
      |=> (cnt_q == $past(cnt_q) - DATA_W'(1)));

   // R9
   stop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_w && !hold_w) |=> $stable(cnt_q));

   // R7
   no_refire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (spent_q && !hold_w) |=> ($stable(cnt_q) && !$rose(ctl_q[B_FLAG])));

   // R6
   flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl_q[B_FLAG]) |-> $past(run_w && !hold_w && at_tc));

   // R8
   flag_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl && wdata[B_FLAG] && !(run_w && !hold_w && !spent_q && at_tc))
      |=> !ctl_q[B_FLAG]);

endmodule

// File: rtl/dtmr_irq_merge.sv
module dtmr_irq_merge #(
   parameter int N       = 2,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   output logic         irq
);

   generate
      if (IRQ_REG) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               irq_q <= 1'b0;
            end else begin
               irq_q <= |req;
            end
         end
         assign irq = irq_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign irq = |req;
      end
   endgenerate

endmodule

// File: rtl/dual_timer.sv
module dual_timer
   import dtmr_pkg::*;
#(
   parameter int NUM_TIMERS = 2,
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 5,
   parameter bit IRQ_REG    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);

   localparam int IDX_NEED = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1;
   localparam int IDX_W    = ADDR_W - 4;

   generate
      if (NUM_TIMERS < 1) begin : g_bad_num
         $error("dual_timer: NUM_TIMERS must be at least 1");
      end
      if (DATA_W < CTL_W) begin : g_bad_width
         $error("dual_timer: DATA_W too narrow for the control word");
      end
      if (IDX_W < IDX_NEED) begin : g_bad_addr
         $error("dual_timer: ADDR_W too small for NUM_TIMERS");
      end
   endgenerate

   logic [IDX_W-1:0]      idx;
   reg_sel_e              sel;
   logic                  aligned;
   logic [NUM_TIMERS-1:0] hit;
   logic [NUM_TIMERS-1:0] req_v;
   logic [NUM_TIMERS-1:0] run_v;
   logic [DATA_W-1:0]     ctl_v  [NUM_TIMERS];
   logic [DATA_W-1:0]     load_v [NUM_TIMERS];
   logic [DATA_W-1:0]     cnt_v  [NUM_TIMERS];
   logic                  all_go;

   assign idx     = bus_addr[ADDR_W-1:4];
   assign sel     = reg_sel_e'(bus_addr[3:2]);
   assign aligned = (bus_addr[1:0] == 2'b00);

   // Enable-all: a control write to any present timer with the go bit
   assign all_go = bus_wr && aligned && (sel == SEL_CTL) && (|hit)
                   && bus_wdata[B_ALLGO];

   generate
      for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
         logic wr_ctl_i, wr_load_i;

         assign hit[i]    = aligned && (idx == IDX_W'(i));
         assign wr_ctl_i  = bus_wr && hit[i] && (sel == SEL_CTL);
         assign wr_load_i = bus_wr && hit[i] && (sel == SEL_LOAD);

         dtmr_channel #(
            .DATA_W (DATA_W)
         ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_ctl  (wr_ctl_i),
            .wr_load (wr_load_i),
            .all_go  (all_go),
            .wdata   (bus_wdata),
            .ctl_o   (ctl_v[i]),
            .load_o  (load_v[i]),
            .cnt_o   (cnt_v[i]),
            .req_o   (req_v[i]),
            .run_o   (run_v[i])
         );
      end
   endgenerate

   // Read mux
   always_comb begin
      bus_rdata = '0;
      for (int k = 0; k < NUM_TIMERS; k++) begin
         if (hit[k]) begin
            case (sel)
               SEL_CTL:  bus_rdata = ctl_v[k];
               SEL_LOAD: bus_rdata = load_v[k];
               SEL_CNT:  bus_rdata = cnt_v[k];
               default:  bus_rdata = '0;
            endcase
         end
      end
   end

   dtmr_irq_merge #(
      .N       (NUM_TIMERS),
      .IRQ_REG (IRQ_REG)
   ) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req_v),
      .irq   (irq)
   );

   // R11
   all_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
      all_go |=> (&run_v));

   // R2
   misalign_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !aligned |-> (bus_rdata == '0));

endmodule

// File: tb/dual_timer_test.sv
module dual_timer_test;

   localparam int CLK_PERIOD = 10;
   localparam int DATA_W     = 32;
   localparam int ADDR_W     = 5;
   localparam int WATCHDOG   = 5000;
   localparam logic [1:0] OPW = 2'd0;
   localparam logic [1:0] OPR = 2'd1;
   localparam int NSTEP = 29;

   // {op, addr, data, irq}
   localparam logic [42:0] TBL [NSTEP] = '{
      {OPW, 8'h04, 32'h0000_0005, 1'b0},
      {OPW, 8'h00, 32'h0000_0020, 1'b0},
      {OPR, 8'h00, 32'h0000_0020, 1'b0},
      {OPR, 8'h08, 32'h0000_0005, 1'b0},
      {OPW, 8'h00, 32'h0000_0092, 1'b0},
      {OPR, 8'h08, 32'h0000_0005, 1'b0},
      {OPR, 8'h08, 32'h0000_0004, 1'b0},
      {OPR, 8'h08, 32'h0000_0003, 1'b0},
      {OPR, 8'h08, 32'h0000_0002, 1'b0},
      {OPR, 8'h08, 32'h0000_0001, 1'b0},
      {OPR, 8'h08, 32'h0000_0000, 1'b0},
      {OPR, 8'h00, 32'h0000_0192, 1'b0},
      {OPR, 8'h08, 32'h0000_0004, 1'b0},
      {OPW, 8'h00, 32'h0000_0192, 1'b0},
      {OPR, 8'h00, 32'h0000_0092, 1'b0},
      {OPR, 8'h08, 32'h0000_0001, 1'b0},
      {OPR, 8'h08, 32'h0000_0000, 1'b0},
      {OPR, 8'h00, 32'h0000_0192, 1'b0},
      {OPW, 8'h00, 32'h0000_00D2, 1'b0},
      {OPR, 8'h00, 32'h0000_01D2, 1'b1},
      {OPW, 8'h00, 32'h0000_0052, 1'b0},
      {OPR, 8'h08, 32'h0000_0001, 1'b1},
      {OPR, 8'h08, 32'h0000_0001, 1'b1},
      {OPW, 8'h08, 32'h0000_0ABC, 1'b0},
      {OPR, 8'h08, 32'h0000_0001, 1'b1},
      {OPR, 8'h0C, 32'h0000_0000, 1'b1},
      {OPW, 8'h00, 32'h0000_0100, 1'b0},
      {OPR, 8'h00, 32'h0000_0000, 1'b0},
      {OPR, 8'h02, 32'h0000_0000, 1'b0}
   };

   localparam string TBL_REQ [NSTEP] = '{
      "R3", "R3", "R2", "R3", "R4", "R4", "R4", "R4", "R4", "R4",
      "R6", "R6", "R6", "R8", "R8", "R4", "R6", "R6", "R10", "R10",
      "R9", "R9", "R9", "R2", "R2", "R2", "R8", "R8", "R2"
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic              bus_wr = 1'b0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic [DATA_W-1:0] bus_rdata;
   logic              irq;

   int chk_cnt  = 0;
   int fail_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_timer #(
      .NUM_TIMERS (2),
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .IRQ_REG    (1'b0)
   ) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   // One write per cycle: driven at the falling edge, taken at the next rise
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr    = 1'b1;
      bus_addr  = a[ADDR_W-1:0];
      bus_wdata = d;
   endtask

   // One read per cycle: sampled just after the falling edge
   task automatic rd(input logic [7:0] a, input logic [31:0] exp_d,
                     input logic exp_irq, input string req);
      @(negedge clk);
      bus_wr   = 1'b0;
      bus_addr = a[ADDR_W-1:0];
      #1;
      chk_cnt++;
      if (bus_rdata !== exp_d || irq !== exp_irq) begin
         fail_cnt++;
         $display("FAIL %s addr=%h rdata got %h exp %h irq got %b exp %b",
                  req, a, bus_rdata, exp_d, irq, exp_irq);
      end
   endtask

   task automatic summary();
      $display("  End of test - %0d assertions evaluated, %0d failures",
               chk_cnt, fail_cnt);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      chk_cnt++;
      fail_cnt++;
      $display("FAIL watchdog (all requirements) got timeout exp completion");
      summary();
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      // R1: reset state, held in reset
      rd(8'h00, 32'h0, 1'b0, "R1");
      rd(8'h18, 32'h0, 1'b0, "R1");
      @(negedge clk);
      rst_n = 1'b1;
      // R1: after release
      rd(8'h00, 32'h0, 1'b0, "R1");
      rd(8'h04, 32'h0, 1'b0, "R1");
      rd(8'h08, 32'h0, 1'b0, "R1");
      rd(8'h10, 32'h0, 1'b0, "R1");
      rd(8'h14, 32'h0, 1'b0, "R1");
      rd(8'h18, 32'h0, 1'b0, "R1");

      // Timer 0 sequence from the table
      for (int i = 0; i < NSTEP; i++) begin
         if (TBL[i][42:41] == OPW) begin
            wr(TBL[i][40:33], TBL[i][32:1]);
         end else begin
            rd(TBL[i][40:33], TBL[i][32:1], TBL[i][0], TBL_REQ[i]);
         end
      end

      // R7 / R5: one-shot up-count on timer 1, holds at all-ones
      wr(8'h14, 32'hFFFF_FFFD);
      wr(8'h10, 32'h0000_0020);
      rd(8'h10, 32'h0000_0020, 1'b0, "R3");
      rd(8'h18, 32'hFFFF_FFFD, 1'b0, "R3");
      wr(8'h10, 32'h0000_0080);
      rd(8'h18, 32'hFFFF_FFFD, 1'b0, "R5");
      rd(8'h18, 32'hFFFF_FFFE, 1'b0, "R5");
      rd(8'h18, 32'hFFFF_FFFF, 1'b0, "R5");
      rd(8'h10, 32'h0000_0180, 1'b0, "R6");
      wr(8'h10, 32'h0000_0180);
      rd(8'h10, 32'h0000_0080, 1'b0, "R7");
      rd(8'h18, 32'hFFFF_FFFF, 1'b0, "R7");

      // R5: free-running reload to zero wraps modulo 2^32
      wr(8'h14, 32'hFFFF_FFFE);
      wr(8'h10, 32'h0000_0020);
      wr(8'h10, 32'h0000_0090);
      wr(8'h14, 32'h0000_0000);
      rd(8'h18, 32'hFFFF_FFFF, 1'b0, "R5");
      rd(8'h18, 32'h0000_0000, 1'b0, "R5");
      rd(8'h18, 32'h0000_0001, 1'b0, "R5");
      rd(8'h10, 32'h0000_0190, 1'b0, "R6");
      // R12: inert bits stored, counting unchanged
      wr(8'h10, 32'h0000_039D);
      rd(8'h10, 32'h0000_029D, 1'b0, "R12");
      rd(8'h18, 32'h0000_0005, 1'b0, "R12");

      // R11: enable-all through timer 0 starts both
      wr(8'h10, 32'h0000_0010);
      wr(8'h00, 32'h0000_0402);
      rd(8'h00, 32'h0000_0082, 1'b0, "R11");
      rd(8'h10, 32'h0000_0090, 1'b0, "R11");
      rd(8'h08, 32'h0000_0000, 1'b0, "R11");
      rd(8'h18, 32'h0000_000A, 1'b0, "R11");

      // R10: timer 0 flag with enable raises irq; ack drops it
      wr(8'h00, 32'h0000_00C2);
      rd(8'h00, 32'h0000_01C2, 1'b1, "R10");
      wr(8'h00, 32'h0000_01C2);
      rd(8'h00, 32'h0000_00C2, 1'b0, "R8");

      // R1: reset while running clears everything
      @(negedge clk);
      rst_n = 1'b0;
      rd(8'h00, 32'h0, 1'b0, "R1");
      rd(8'h14, 32'h0, 1'b0, "R1");
      rd(8'h18, 32'h0, 1'b0, "R1");

      summary();
      $finish;
   end

endmodule